// File: doc/BRIEF.md
# Partitioned gshare Direction and Pointer Predictor

This block is a gshare pattern history table of 2-bit saturating counters that serves two kinds of branch. For a conditional branch it works as an ordinary gshare predictor. The program counter is XORed with the global history, and the result picks one counter out of the whole table. The high bit of that counter is the predicted direction.

For an indirect branch the same storage is treated as four independent quarter-size tables. All four are indexed at once with the low bits of the program counter XORed with the low bits of the history. The high bit of the counter each quarter selects becomes one bit of a 4-bit target pointer. A separate target store turns that pointer into an address. Any bimodal or chooser logic that sits around this table is not part of the block and plays no part in pointer mode.

A per-bank index multiplexer chooses between the two indexing schemes, and the training port can update either way. A direction update moves one counter toward the resolved outcome. A pointer update moves one counter in every bank, each toward its own bit of the correct pointer. The table geometry is set by parameters. The full-size configuration uses `BANK_IDX_W = 13`, which gives 32K counters. The default is smaller so that elaboration stays light.

Top module: `gshare_ptr_predictor`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not-taken). A direction lookup therefore returns not-taken, a pointer lookup returns 4'b0000, and `resp_valid_o` is low.
- R2: A lookup presented with `pred_valid_i` high is answered in the next cycle. In that cycle `resp_valid_o` is high and `resp_ptr_mode_o` equals the mode of the request. A cycle with no request produces `resp_valid_o` low in the following cycle.
- R3: Direction mode (`pred_ptr_mode_i` = 0) forms the index as `pc ^ hist` over FULL_W bits. The top SEL_W bits select the bank and the low BANK_IDX_W bits select the counter inside it. `resp_taken_o` is the high bit of that counter, and `resp_ptr_o` is 0.
- R4: Pointer mode (`pred_ptr_mode_i` = 1) indexes every bank b with `pc[BANK_IDX_W-1:0] ^ hist[BANK_IDX_W-1:0]`. `resp_ptr_o[b]` is the high bit of bank b's counter, with 1 meaning taken, and `resp_taken_o` is 0.
- R5: A direction update (`upd_ptr_mode_i` = 0) changes only the counter at the full direction index. Counters at the same in-bank index in other banks are left unchanged.
- R6: A pointer update (`upd_ptr_mode_i` = 1) changes, in every bank b, the counter at the pointer index. Each one moves up when `upd_ptr_i[b]` is 1 and down when it is 0.
- R7: Counters saturate at 2'b11 and 2'b00. A further step in the same direction leaves the counter unchanged.
- R8: When a lookup and an update reach the same counter in the same cycle, the lookup returns the value from before the update. The update is visible to the next lookup.
- R9: Both modes share one set of counters. Pointer training of bank b at in-bank index i changes the direction prediction whose full index has bank field b and in-bank field i, and the reverse is also true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid_i | input | 1 | Lookup request |
| pred_ptr_mode_i | input | 1 | Lookup mode: 0 direction, 1 pointer |
| pred_pc_i | input | BANK_IDX_W+SEL_W | Lookup program counter bits |
| pred_hist_i | input | BANK_IDX_W+SEL_W | Lookup global history |
| resp_valid_o | output | 1 | Response valid, one cycle after request |
| resp_ptr_mode_o | output | 1 | Mode of the answered request |
| resp_taken_o | output | 1 | Predicted direction (direction mode) |
| resp_ptr_o | output | 2**SEL_W | Predicted target pointer (pointer mode) |
| upd_valid_i | input | 1 | Training request |
| upd_ptr_mode_i | input | 1 | Training mode: 0 direction, 1 pointer |
| upd_pc_i | input | BANK_IDX_W+SEL_W | Training program counter bits |
| upd_hist_i | input | BANK_IDX_W+SEL_W | Training global history |
| upd_taken_i | input | 1 | Resolved direction for direction training |
| upd_ptr_i | input | 2**SEL_W | Correct pointer for pointer training |

## Verification
A lookup and a training write can reach the same counter in the same cycle. This happens in both modes. The bench provokes it by presenting a request and an update with the same index in one cycle, each time at a counter still at its reset value. It then checks that the response carries the old value: not-taken for direction, 4'b0000 for pointer. A second lookup must then show the stepped value: taken, and 4'b1111 after an all-ones pointer update.

// File: rtl/gptr_pkg.sv
package gptr_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'b01;

    // one saturating step of a 2-bit counter
    function automatic ctr_t ctr_step(ctr_t c, logic up);
        ctr_t r;
        if (up) begin
            r = (c == 2'b11) ? c : c + 2'd1;
        end else begin
            r = (c == 2'b00) ? c : c - 2'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/gptr_index.sv
module gptr_index #(
    parameter int IDX_W = 8,
    parameter int SEL_W = 2,
    localparam int NB     = 1 << SEL_W,
    localparam int FULL_W = IDX_W + SEL_W
) (
    input  logic                       ptr_mode_i,
    input  logic [FULL_W-1:0]          pc_i,
    input  logic [FULL_W-1:0]          hist_i,
    output logic [NB-1:0][IDX_W-1:0]   bank_idx_o,
    output logic [NB-1:0]              bank_en_o
);

    logic [FULL_W-1:0] full_hash;
    logic [SEL_W-1:0]  bank_sel;
    logic [IDX_W-1:0]  dir_idx;
    logic [IDX_W-1:0]  ptr_idx;

    always_comb begin
        full_hash = pc_i ^ hist_i;
        bank_sel  = full_hash[FULL_W-1 -: SEL_W];
        dir_idx   = full_hash[IDX_W-1:0];
        ptr_idx   = pc_i[IDX_W-1:0] ^ hist_i[IDX_W-1:0];
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank_mux
        assign bank_idx_o[b] = ptr_mode_i ? ptr_idx : dir_idx;
        assign bank_en_o[b]  = ptr_mode_i | (bank_sel == SEL_W'(b));
    end

endmodule

// File: rtl/gptr_bank.sv
module gptr_bank
    import gptr_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_up_i,
    output ctr_t             rd_ctr_o
);

    ctr_t mem_q [DEPTH];
    ctr_t rd_d, rd_q;
    ctr_t wr_old, wr_new;

    always_comb begin
        wr_old = mem_q[wr_idx_i];
        wr_new = ctr_step(wr_old, wr_up_i);
        rd_d   = rd_en_i ? mem_q[rd_idx_i] : rd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= CTR_INIT;
            end
            rd_q <= CTR_INIT;
        end else begin
            rd_q <= rd_d;
            if (wr_en_i) begin
                mem_q[wr_idx_i] <= wr_new;
            end
        end
    end

    assign rd_ctr_o = rd_q;

    a_r7_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_up_i && wr_old == 2'b11) |=> (mem_q[$past(wr_idx_i)] == 2'b11));

    a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_up_i && wr_old == 2'b00) |=> (mem_q[$past(wr_idx_i)] == 2'b00));

    a_r8_read_old: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && wr_en_i && rd_idx_i == wr_idx_i) |=> (rd_q == $past(wr_old)));

endmodule

// File: rtl/gshare_ptr_predictor.sv
module gshare_ptr_predictor
    import gptr_pkg::*;
#(
    parameter int BANK_IDX_W = 8,
    parameter int SEL_W      = 2,
    localparam int NB     = 1 << SEL_W,
    localparam int FULL_W = BANK_IDX_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid_i,
    input  logic              pred_ptr_mode_i,
    input  logic [FULL_W-1:0] pred_pc_i,
    input  logic [FULL_W-1:0] pred_hist_i,
    output logic              resp_valid_o,
    output logic              resp_ptr_mode_o,
    output logic              resp_taken_o,
    output logic [NB-1:0]     resp_ptr_o,
    input  logic              upd_valid_i,
    input  logic              upd_ptr_mode_i,
    input  logic [FULL_W-1:0] upd_pc_i,
    input  logic [FULL_W-1:0] upd_hist_i,
    input  logic              upd_taken_i,
    input  logic [NB-1:0]     upd_ptr_i
);

    typedef struct packed {
        logic          valid;
        logic          ptr_mode;
        logic [NB-1:0] bank_en;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [NB-1:0][BANK_IDX_W-1:0] p_idx, u_idx;
    logic [NB-1:0]                 p_en, u_en;
    logic [NB-1:0]                 rd_en, wr_en, wr_up, ctr_msb;

    gptr_index #(.IDX_W(BANK_IDX_W), .SEL_W(SEL_W)) u_pred_idx (
        .ptr_mode_i (pred_ptr_mode_i),
        .pc_i       (pred_pc_i),
        .hist_i     (pred_hist_i),
        .bank_idx_o (p_idx),
        .bank_en_o  (p_en)
    );

    gptr_index #(.IDX_W(BANK_IDX_W), .SEL_W(SEL_W)) u_upd_idx (
        .ptr_mode_i (upd_ptr_mode_i),
        .pc_i       (upd_pc_i),
        .hist_i     (upd_hist_i),
        .bank_idx_o (u_idx),
        .bank_en_o  (u_en)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        ctr_t rd_ctr;

        assign rd_en[b]   = pred_valid_i & p_en[b];
        assign wr_en[b]   = upd_valid_i & u_en[b];
        assign wr_up[b]   = upd_ptr_mode_i ? upd_ptr_i[b] : upd_taken_i;
        assign ctr_msb[b] = rd_ctr[1];

        gptr_bank #(.IDX_W(BANK_IDX_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_en_i  (rd_en[b]),
            .rd_idx_i (p_idx[b]),
            .wr_en_i  (wr_en[b]),
            .wr_idx_i (u_idx[b]),
            .wr_up_i  (wr_up[b]),
            .rd_ctr_o (rd_ctr)
        );
    end

    always_comb begin
        stage_d          = stage_q;
        stage_d.valid    = pred_valid_i;
        if (pred_valid_i) begin
            stage_d.ptr_mode = pred_ptr_mode_i;
            stage_d.bank_en  = p_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    always_comb begin
        resp_valid_o    = stage_q.valid;
        resp_ptr_mode_o = stage_q.ptr_mode;
        resp_taken_o    = stage_q.valid && !stage_q.ptr_mode && |(stage_q.bank_en & ctr_msb);
        resp_ptr_o      = (stage_q.valid && stage_q.ptr_mode) ? ctr_msb : '0;
    end

    a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_i |=> (resp_valid_o && resp_ptr_mode_o == $past(pred_ptr_mode_i)));

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_i |=> !resp_valid_o);

    a_r5_one_bank_trained: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && !upd_ptr_mode_i) |-> ($countones(wr_en) == 1));

    a_r6_all_banks_trained: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && upd_ptr_mode_i) |-> (&wr_en));

    a_r4_direction_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_ptr_mode_o) |-> !resp_taken_o);

endmodule

// File: tb/gshare_ptr_predictor_bench.sv
module gshare_ptr_predictor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BIW = 8;
    localparam int SW  = 2;
    localparam int NB  = 1 << SW;
    localparam int FW  = BIW + SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_valid_i = 1'b0;
    logic          pred_ptr_mode_i = 1'b0;
    logic [FW-1:0] pred_pc_i = '0;
    logic [FW-1:0] pred_hist_i = '0;
    logic          resp_valid_o;
    logic          resp_ptr_mode_o;
    logic          resp_taken_o;
    logic [NB-1:0] resp_ptr_o;
    logic          upd_valid_i = 1'b0;
    logic          upd_ptr_mode_i = 1'b0;
    logic [FW-1:0] upd_pc_i = '0;
    logic [FW-1:0] upd_hist_i = '0;
    logic          upd_taken_i = 1'b0;
    logic [NB-1:0] upd_ptr_i = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gshare_ptr_predictor #(.BANK_IDX_W(BIW), .SEL_W(SW)) u_gshare_ptr_predictor (
        .clk             (clk),
        .rst_n           (rst_n),
        .pred_valid_i    (pred_valid_i),
        .pred_ptr_mode_i (pred_ptr_mode_i),
        .pred_pc_i       (pred_pc_i),
        .pred_hist_i     (pred_hist_i),
        .resp_valid_o    (resp_valid_o),
        .resp_ptr_mode_o (resp_ptr_mode_o),
        .resp_taken_o    (resp_taken_o),
        .resp_ptr_o      (resp_ptr_o),
        .upd_valid_i     (upd_valid_i),
        .upd_ptr_mode_i  (upd_ptr_mode_i),
        .upd_pc_i        (upd_pc_i),
        .upd_hist_i      (upd_hist_i),
        .upd_taken_i     (upd_taken_i),
        .upd_ptr_i       (upd_ptr_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_pred(input logic mode, input logic [FW-1:0] pc, input logic [FW-1:0] hist);
        pred_valid_i = 1'b1; pred_ptr_mode_i = mode; pred_pc_i = pc; pred_hist_i = hist;
    endtask

    task automatic set_upd(input logic mode, input logic [FW-1:0] pc, input logic [FW-1:0] hist,
                           input logic taken, input logic [NB-1:0] ptr);
        upd_valid_i = 1'b1; upd_ptr_mode_i = mode; upd_pc_i = pc; upd_hist_i = hist;
        upd_taken_i = taken; upd_ptr_i = ptr;
    endtask

    task automatic step_and_clear();
        @(posedge clk);
        @(negedge clk);
        pred_valid_i = 1'b0;
        upd_valid_i  = 1'b0;
    endtask

    // outputs sampled at the negedge after the request edge
    task automatic check_resp(input string req, input logic mode, input logic exp_taken,
                              input logic [NB-1:0] exp_ptr);
        check(resp_valid_o == 1'b1, {req, " valid"}, resp_valid_o, 1);
        check(resp_ptr_mode_o == mode, {req, " mode"}, resp_ptr_mode_o, mode);
        check(resp_taken_o == exp_taken, {req, " taken"}, resp_taken_o, exp_taken);
        check(resp_ptr_o == exp_ptr, {req, " ptr"}, resp_ptr_o, exp_ptr);
    endtask

    task automatic lookup(input string req, input logic mode, input logic [FW-1:0] pc,
                          input logic [FW-1:0] hist, input logic exp_taken, input logic [NB-1:0] exp_ptr);
        set_pred(mode, pc, hist);
        step_and_clear();
        check_resp(req, mode, exp_taken, exp_ptr);
    endtask

    task automatic train(input logic mode, input logic [FW-1:0] pc, input logic [FW-1:0] hist,
                         input logic taken, input logic [NB-1:0] ptr);
        set_upd(mode, pc, hist, taken, ptr);
        step_and_clear();
    endtask

    task automatic t_reset_state();
        check(resp_valid_o == 1'b0, "R1 idle after reset", resp_valid_o, 0);
        lookup("R1 dir init", 1'b0, 10'h300, 10'h000, 1'b0, 4'b0000);
        lookup("R1 ptr init", 1'b1, 10'h000, 10'h000, 1'b0, 4'b0000);
        @(posedge clk); @(negedge clk);
        check(resp_valid_o == 1'b0, "R2 no request no response", resp_valid_o, 0);
    endtask

    task automatic t_dir_train();
        // full index 0x255: bank 2, entry 0x55
        train(1'b0, 10'h2A5, 10'h0F0, 1'b1, '0);
        train(1'b0, 10'h2A5, 10'h0F0, 1'b1, '0);
        lookup("R3 dir trained", 1'b0, 10'h2A5, 10'h0F0, 1'b1, 4'b0000);
        lookup("R5 R9 other banks untouched", 1'b1, 10'h055, 10'h000, 1'b0, 4'b0100);
        lookup("R3 other bank same entry", 1'b0, 10'h055, 10'h000, 1'b0, 4'b0000);
    endtask

    task automatic t_ptr_train();
        // pointer entry 0x13 ^ 0xA0 = 0xB3
        train(1'b1, 10'h013, 10'h3A0, 1'b0, 4'b1010);
        train(1'b1, 10'h013, 10'h3A0, 1'b0, 4'b1010);
        lookup("R4 R6 ptr trained", 1'b1, 10'h013, 10'h3A0, 1'b0, 4'b1010);
        lookup("R4 ptr upper bits ignored", 1'b1, 10'h2B3, 10'h000, 1'b0, 4'b1010);
        lookup("R9 dir bank3", 1'b0, 10'h3B3, 10'h000, 1'b1, 4'b0000);
        lookup("R9 dir bank1", 1'b0, 10'h1B3, 10'h000, 1'b1, 4'b0000);
        lookup("R9 dir bank0", 1'b0, 10'h0B3, 10'h000, 1'b0, 4'b0000);
        lookup("R9 dir bank2", 1'b0, 10'h2B3, 10'h000, 1'b0, 4'b0000);
    endtask

    task automatic t_saturation();
        // bank 0 entry 0x11
        for (int i = 0; i < 5; i++) train(1'b0, 10'h011, 10'h000, 1'b1, '0);
        train(1'b0, 10'h011, 10'h000, 1'b0, '0);
        lookup("R7 top saturation", 1'b0, 10'h011, 10'h000, 1'b1, 4'b0000);
        train(1'b0, 10'h011, 10'h000, 1'b0, '0);
        lookup("R7 step down from top", 1'b0, 10'h011, 10'h000, 1'b0, 4'b0000);
        for (int i = 0; i < 4; i++) train(1'b0, 10'h011, 10'h000, 1'b0, '0);
        train(1'b0, 10'h011, 10'h000, 1'b1, '0);
        lookup("R7 bottom saturation", 1'b0, 10'h011, 10'h000, 1'b0, 4'b0000);
        train(1'b0, 10'h011, 10'h000, 1'b1, '0);
        lookup("R7 step up from bottom", 1'b0, 10'h011, 10'h000, 1'b1, 4'b0000);
    endtask

    task automatic t_same_cycle();
        // direction: bank 1 entry 0xC7, fresh
        set_pred(1'b0, 10'h1C7, 10'h000);
        set_upd(1'b0, 10'h1C7, 10'h000, 1'b1, '0);
        step_and_clear();
        check_resp("R8 dir old value", 1'b0, 1'b0, 4'b0000);
        lookup("R8 dir new value", 1'b0, 10'h1C7, 10'h000, 1'b1, 4'b0000);
        // pointer: entry 0xE4, fresh
        set_pred(1'b1, 10'h0E4, 10'h000);
        set_upd(1'b1, 10'h0E4, 10'h000, 1'b0, 4'b1111);
        step_and_clear();
        check_resp("R8 ptr old value", 1'b1, 1'b0, 4'b0000);
        lookup("R8 ptr new value", 1'b1, 10'h0E4, 10'h000, 1'b0, 4'b1111);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_dir_train();
        t_ptr_train();
        t_saturation();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule